// File: doc/BRIEF.md
# Input Power-Path Sleep Sequencer

This block decides which of two power switches feeds the system: the input switch from the adapter, or the battery switch. It works from two digitized comparator flags. The first says the adapter voltage sits above the battery. The second says the system rail has sagged close to the battery. A one-microsecond tick strobe is the time base for every delay.

When the adapter flag drops and stays low, the block shuts down in three timed stages. First it stops charging. Later it opens the input switch. Last it enters a low-power sleep state, in which the reference-enable output is withdrawn. Any return of the flag before a stage is reached cancels the count, and the next drop starts again from zero. Leaving sleep needs the adapter flag to stay high for a set time.

The battery switch follows a filtered version of the near-battery flag, with different persistence times for turning on and turning off. From reset, and again after each sleep, the battery switch is kept requested until the adapter has been present for a hand-over delay. A break-before-make interlock keeps the two switches apart in time.

Top module: `power_path_sleep_seq`

## Requirements
- R1: While reset is asserted and directly after it, chargeDisable=1, sleep=1, vrefEn=0, acfetOn=0 and batfetOn=0.
- R2: chargeDisable becomes 1 on the clock edge after the adapter flag has been low for T_CHGOFF_US ticks. It returns to 0 one edge after the flag is high again, unless the block is asleep.
- R3: acfetOn becomes 0 on the clock edge after the adapter flag has been low for T_INOFF_US ticks.
- R4: sleep becomes 1, and vrefEn becomes 0, on the clock edge after the adapter flag has been low for T_SLEEP_US ticks. While asleep, chargeDisable stays 1 and acfetOn stays 0.
- R5: A sleeping block wakes (sleep=0, vrefEn=1, chargeDisable=0) on the clock edge after the adapter flag has been high for T_WAKE_US ticks.
- R6: Any cycle with the adapter flag high clears the low-time count. A later drop restarts all three stages from zero.
- R7: The internal battery request rises after nearBat has been 1 for T_BATON_US ticks and falls after nearBat has been 0 for T_BATOFF_US ticks. A sample that agrees with the current request restarts the count.
- R8: From reset, and after every sleep entry, the battery switch stays requested until the adapter flag has been high for T_HANDOVER_US ticks. That hand-over then holds until the next sleep entry.
- R9: The battery request has priority. A raised battery request opens the input switch on the next edge. The input switch closes only when it is requested and the battery is not.
- R10: acfetOn and batfetOn are never 1 together. A switch turns on only after both have been off for T_DEAD_US ticks, on the edge after that count is reached.
- R11: Every delay advances only on cycles with tickUs=1. Without ticks, no stage, filter or dead-time count moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickUs | input | 1 | One-cycle strobe each microsecond |
| adapterAbove | input | 1 | 1 when the adapter voltage is above the battery |
| nearBat | input | 1 | 1 when the system rail is close to the battery |
| chargeDisable | output | 1 | 1 stops charging |
| acfetOn | output | 1 | Input switch enable |
| batfetOn | output | 1 | Battery switch enable |
| sleep | output | 1 | Low-power sleep state |
| vrefEn | output | 1 | Reference enable, inverse of sleep |

## Verification
With a tick on every cycle, each threshold output is registered. It changes on the edge after its count reaches the limit, so a T-tick delay appears after T+1 clock edges. A switch hand-over adds the filter time, one edge to open the old switch, T_DEAD_US edges of counting and one more edge to close the new switch. The bench drives inputs on falling edges and checks each result twice on falling edges: once at the last edge before it is due, and once at the edge where it appears. This pins every latency exactly. Separate runs with the tick held low show that nothing advances without it.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // threshold status from the timer datapath
  typedef struct packed {
    logic chgOffHit;
    logic inOffHit;
    logic sleepHit;
    logic wakeHit;
    logic handHit;
    logic batFilt;
    logic deadDone;
  } tmrStat_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic deadClr;
  } ctlStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pss_persist.sv
module pss_persist #(
  parameter int MAXV = 8,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickUs,
  input  logic         run,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] LIMIT = W'(MAXV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cnt <= '0;
    else if (!run)                   cnt <= '0;
    else if (tickUs && cnt < LIMIT)  cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/pss_timers.sv
module pss_timers
  import pss_pkg::*;
#(
  parameter int T_CHGOFF_US   = 1000,
  parameter int T_INOFF_US    = 5000,
  parameter int T_SLEEP_US    = 100000,
  parameter int T_WAKE_US     = 30000,
  parameter int T_BATON_US    = 2000,
  parameter int T_BATOFF_US   = 50,
  parameter int T_DEAD_US     = 10,
  parameter int T_HANDOVER_US = 30000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickUs,
  input  logic       adapterAbove,
  input  logic       nearBat,
  input  ctlStrobe_t ctl,
  output tmrStat_t   stat
);

  localparam int HIGH_MAX = maxOf(T_WAKE_US, T_HANDOVER_US);
  localparam int LW = $clog2(T_SLEEP_US + 1);
  localparam int HW = $clog2(HIGH_MAX + 1);
  localparam int BW = $clog2(maxOf(T_BATON_US, T_BATOFF_US) + 1);
  localparam int DW = $clog2(T_DEAD_US + 1);

  logic [LW-1:0] lowCnt;
  logic [HW-1:0] highCnt;
  logic [BW-1:0] batCnt;
  logic [BW-1:0] batLimit;
  logic [DW-1:0] deadCnt;
  logic          batFilt;

  pss_persist #(.MAXV(T_SLEEP_US)) u_low (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .run(~adapterAbove), .cnt(lowCnt)
  );

  pss_persist #(.MAXV(HIGH_MAX)) u_high (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .run(adapterAbove), .cnt(highCnt)
  );

  // asymmetric persistence filter on the near-battery flag
  assign batLimit = batFilt ? BW'(T_BATOFF_US) : BW'(T_BATON_US);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      batFilt <= 1'b0;
      batCnt  <= '0;
    end else if (nearBat == batFilt) begin
      batCnt <= '0;
    end else if (tickUs) begin
      if (batCnt + BW'(1) >= batLimit) begin
        batFilt <= ~batFilt;
        batCnt  <= '0;
      end else begin
        batCnt <= batCnt + BW'(1);
      end
    end
  end

  // break-before-make counter, runs only while both switches are open
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     deadCnt <= '0;
    else if (ctl.deadClr)                          deadCnt <= '0;
    else if (tickUs && deadCnt < DW'(T_DEAD_US))   deadCnt <= deadCnt + DW'(1);
  end

  assign stat.chgOffHit = lowCnt  >= LW'(T_CHGOFF_US);
  assign stat.inOffHit  = lowCnt  >= LW'(T_INOFF_US);
  assign stat.sleepHit  = lowCnt  >= LW'(T_SLEEP_US);
  assign stat.wakeHit   = highCnt >= HW'(T_WAKE_US);
  assign stat.handHit   = highCnt >= HW'(T_HANDOVER_US);
  assign stat.batFilt   = batFilt;
  assign stat.deadDone  = deadCnt >= DW'(T_DEAD_US);

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tmrStat_t   stat,
  output ctlStrobe_t ctl,
  output logic       chargeDisable,
  output logic       acfetOn,
  output logic       batfetOn,
  output logic       sleepQ
);

  logic seenQ, seenNext, sleepNext;
  logic acReq, batReq, acNext, batNext;

  always_comb begin
    sleepNext = sleepQ;
    if (sleepQ && stat.wakeHit)        sleepNext = 1'b0;
    else if (!sleepQ && stat.sleepHit) sleepNext = 1'b1;

    // hand-over flag: set once the adapter has persisted, dropped on sleep
    seenNext = sleepNext ? 1'b0 : (seenQ | stat.handHit);

    batReq = stat.batFilt | ~seenQ;
    acReq  = ~stat.inOffHit & ~sleepQ;

    acNext  = acfetOn;
    batNext = batfetOn;
    if (acfetOn) begin
      acNext = acReq & ~batReq;
    end else if (batfetOn) begin
      batNext = batReq;
    end else if (stat.deadDone) begin
      if (batReq)     batNext = 1'b1;
      else if (acReq) acNext  = 1'b1;
    end
  end

  assign ctl.deadClr = acfetOn | batfetOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepQ        <= 1'b1;
      seenQ         <= 1'b0;
      chargeDisable <= 1'b1;
      acfetOn       <= 1'b0;
      batfetOn      <= 1'b0;
    end else begin
      sleepQ        <= sleepNext;
      seenQ         <= seenNext;
      chargeDisable <= sleepNext | stat.chgOffHit;
      acfetOn       <= acNext;
      batfetOn      <= batNext;
    end
  end

endmodule

// File: rtl/power_path_sleep_seq.sv
module power_path_sleep_seq
  import pss_pkg::*;
#(
  parameter int T_CHGOFF_US   = 1000,
  parameter int T_INOFF_US    = 5000,
  parameter int T_SLEEP_US    = 100000,
  parameter int T_WAKE_US     = 30000,
  parameter int T_BATON_US    = 2000,
  parameter int T_BATOFF_US   = 50,
  parameter int T_DEAD_US     = 10,
  parameter int T_HANDOVER_US = 30000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickUs,
  input  logic adapterAbove,
  input  logic nearBat,
  output logic chargeDisable,
  output logic acfetOn,
  output logic batfetOn,
  output logic sleep,
  output logic vrefEn
);

  tmrStat_t   stat;
  ctlStrobe_t ctl;
  logic       sleepQ;

  pss_timers #(
    .T_CHGOFF_US(T_CHGOFF_US), .T_INOFF_US(T_INOFF_US), .T_SLEEP_US(T_SLEEP_US),
    .T_WAKE_US(T_WAKE_US), .T_BATON_US(T_BATON_US), .T_BATOFF_US(T_BATOFF_US),
    .T_DEAD_US(T_DEAD_US), .T_HANDOVER_US(T_HANDOVER_US)
  ) u_timers (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .adapterAbove(adapterAbove),
    .nearBat(nearBat), .ctl(ctl), .stat(stat)
  );

  pss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .ctl(ctl),
    .chargeDisable(chargeDisable), .acfetOn(acfetOn), .batfetOn(batfetOn),
    .sleepQ(sleepQ)
  );

  assign sleep  = sleepQ;
  assign vrefEn = ~sleepQ;

endmodule

// File: rtl/pss_chk.sv
module pss_chk (
  input logic clk,
  input logic rstN,
  input logic adapterAbove,
  input logic chargeDisable,
  input logic acfetOn,
  input logic batfetOn,
  input logic sleep
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(acfetOn && batfetOn));

  p_ac_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acfetOn) |-> $past(!batfetOn));

  p_bat_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(batfetOn) |-> $past(!acfetOn));

  p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (chargeDisable && !acfetOn));

  p_enter_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleep) |-> $past(!adapterAbove));

  p_leave_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleep) |-> $past(adapterAbove));

  p_chg_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chargeDisable) |-> !sleep);

endmodule

bind power_path_sleep_seq pss_chk u_chk (
  .clk(clk), .rstN(rstN), .adapterAbove(adapterAbove),
  .chargeDisable(chargeDisable), .acfetOn(acfetOn), .batfetOn(batfetOn),
  .sleep(sleep)
);

// File: tb/sim_power_path_sleep_seq.sv
`timescale 1ns/100ps
module sim_power_path_sleep_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 1'b1;
  logic adapterAbove = 1'b0;
  logic nearBat = 1'b0;
  logic chargeDisable, acfetOn, batfetOn, sleep, vrefEn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  power_path_sleep_seq #(
    .T_CHGOFF_US(4), .T_INOFF_US(10), .T_SLEEP_US(30), .T_WAKE_US(12),
    .T_BATON_US(6), .T_BATOFF_US(3), .T_DEAD_US(2), .T_HANDOVER_US(20)
  ) u0 (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .adapterAbove(adapterAbove),
    .nearBat(nearBat), .chargeDisable(chargeDisable), .acfetOn(acfetOn),
    .batfetOn(batfetOn), .sleep(sleep), .vrefEn(vrefEn)
  );

  // outputs packed as {chargeDisable, acfetOn, batfetOn, sleep, vrefEn}
  typedef struct packed {
    logic       adp;
    logic       near;
    logic [7:0] waitN;
    logic [4:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd2,  5'b10010, 4'd10}, // R10 dead time before first close
    '{1'b0, 1'b0, 8'd1,  5'b10110, 4'd8},  // R8 battery requested from reset
    '{1'b1, 1'b0, 8'd12, 5'b10110, 4'd5},  // R5 still asleep
    '{1'b1, 1'b0, 8'd1,  5'b00101, 4'd5},  // R5 wake
    '{1'b1, 1'b0, 8'd8,  5'b00101, 4'd8},  // R8 hand-over not yet
    '{1'b1, 1'b0, 8'd1,  5'b00001, 4'd8},  // R8 battery opens
    '{1'b1, 1'b0, 8'd2,  5'b00001, 4'd10}, // R10 gap
    '{1'b1, 1'b0, 8'd1,  5'b01001, 4'd10}, // R10 input closes
    '{1'b0, 1'b0, 8'd4,  5'b01001, 4'd2},  // R2 before limit
    '{1'b0, 1'b0, 8'd1,  5'b11001, 4'd2},  // R2 charging stops
    '{1'b0, 1'b0, 8'd5,  5'b11001, 4'd3},  // R3 before limit
    '{1'b0, 1'b0, 8'd1,  5'b10001, 4'd3},  // R3 input opens
    '{1'b0, 1'b0, 8'd19, 5'b10001, 4'd4},  // R4 before limit
    '{1'b0, 1'b0, 8'd1,  5'b10010, 4'd4},  // R4 sleep
    '{1'b0, 1'b0, 8'd1,  5'b10110, 4'd8},  // R8 hand-over cleared on sleep
    '{1'b1, 1'b0, 8'd25, 5'b01001, 4'd5},  // R5 second wake and hand-over
    '{1'b0, 1'b0, 8'd7,  5'b11001, 4'd2},  // R2 short drop
    '{1'b1, 1'b0, 8'd1,  5'b11001, 4'd6},  // R6 recovery edge
    '{1'b1, 1'b0, 8'd1,  5'b01001, 4'd6},  // R6 charging resumes
    '{1'b0, 1'b0, 8'd4,  5'b01001, 4'd6},  // R6 count restarted
    '{1'b0, 1'b0, 8'd1,  5'b11001, 4'd6},  // R6 fresh stage one
    '{1'b1, 1'b0, 8'd2,  5'b01001, 4'd6},  // R6 recover again
    '{1'b1, 1'b1, 8'd6,  5'b01001, 4'd7},  // R7 filter reached
    '{1'b1, 1'b1, 8'd1,  5'b00001, 4'd9},  // R9 input opens for battery
    '{1'b1, 1'b1, 8'd2,  5'b00001, 4'd10}, // R10 gap
    '{1'b1, 1'b1, 8'd1,  5'b00101, 4'd10}, // R10 battery closes
    '{1'b1, 1'b0, 8'd3,  5'b00101, 4'd7},  // R7 release filter reached
    '{1'b1, 1'b0, 8'd1,  5'b00001, 4'd7},  // R7 battery opens
    '{1'b1, 1'b0, 8'd2,  5'b00001, 4'd10}, // R10 gap
    '{1'b1, 1'b0, 8'd1,  5'b01001, 4'd9},  // R9 input closes again
    '{1'b1, 1'b1, 8'd5,  5'b01001, 4'd7},  // R7 short near pulse
    '{1'b1, 1'b0, 8'd1,  5'b01001, 4'd7},  // R7 count cleared
    '{1'b1, 1'b1, 8'd5,  5'b01001, 4'd7},  // R7 restarts from zero
    '{1'b1, 1'b0, 8'd1,  5'b01001, 4'd7}   // R7 no flip
  };

  function automatic logic [4:0] outs();
    return {chargeDisable, acfetOn, batfetOn, sleep, vrefEn};
  endfunction

  task automatic check(input logic [4:0] exp, input int req, input string what);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, outs(), exp);
    end
  endtask

  task automatic step(input logic adp, input logic near, input int n);
    adapterAbove = adp;
    nearBat = near;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(5'b10010, 1, "in reset");              // R1
    rstN = 1'b1;
    check(5'b10010, 1, "after release");         // R1

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].adp, VECS[i].near, int'(VECS[i].waitN));
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R11: no ticks, adapter low and near flag high must move nothing
    tickUs = 1'b0;
    step(1'b0, 1'b1, 40);
    check(5'b01001, 11, "no tick frozen");       // R11
    tickUs = 1'b1;
    step(1'b1, 1'b0, 2);
    check(5'b01001, 11, "tick restored");        // R11

    // R1: reset in the middle of operation
    rstN = 1'b0;
    @(negedge clk);
    check(5'b10010, 1, "mid-run reset");         // R1

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule